// File: doc/BRIEF.md
# External-Master Chip-Select Acknowledge Responder

While another master drives the shared bus, this block decodes the master's address against a set of programmable chip-select windows. Each window has a base, a don't-care mask, an enable for hits from external masters, an auto-acknowledge enable, a lane-enable switch and a wait-state count. When a cycle starts in an enabled window, the block asserts that window's chip select and the byte-lane enables for a 32-bit port. If the window allows it, the block returns a one-clock transfer acknowledge after the programmed number of wait states.

A cycle is opened by either the transfer-start input or the address-strobe input. Both inputs in the same clock is a protocol error. Reads and writes are handled the same way, so the block has no read/write input. The block produces only control signals. Data, arbitration and memory-controller timing belong to the neighbouring logic. Every pin is a plain level signal with no handshake, because the bus master sets the pace and the block only follows it.

Top module: `emcs_responder`

## Requirements
- R1: A window matches when `(addr ^ base) & ~mask` is zero. Of all matching eligible windows, the lowest-numbered one wins, and its chip select is the only one asserted (chip_sel bit i belongs to window i). A start that matches no eligible window opens no cycle.
- R2: A window whose external-master enable bit is 0 never wins, even when its address matches. A higher-numbered enabled window that also matches is selected instead.
- R3: A cycle starts on a clock edge where exactly one of xfer_start and addr_strobe is high. If both are high, no cycle starts and proto_err is high for the single following clock.
- R4: The lane enables are valid while the cycle is open. lane_en[3] is byte offset 0 and lane_en[0] is offset 3. The size codes decode as follows:
  - size 01 (byte) gives `4'b1000 >> addr[1:0]`.
  - size 10 (word) gives 1100 when addr[1] is 0 and 0011 when addr[1] is 1.
  - sizes 00 and 11 give 1111.
  - lane_en stays 0 when the window's lane switch is 0.
- R5: Chip select appears in the clock after the start edge. With N programmed wait states, xfer_ack is high in the (N+1)-th clock of the cycle. Starts seen while an auto-acknowledged cycle is still waiting are ignored.
- R6: xfer_ack is a single-clock pulse. If no new cycle starts on the edge that ends the acknowledge clock, chip select and lane enables return to 0 on that edge.
- R7: With zero wait states, a start on the edge that ends the acknowledge clock opens the next cycle at once, with no idle clock between the two.
- R8: In a window with auto-acknowledge off, the block holds chip select and never asserts xfer_ack. The hold lasts until the next valid start. That start either opens a new cycle or, if it matches nothing, closes the held one.
- R9: After reset, chip_sel, lane_en, xfer_ack and proto_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Address driven by the external master |
| bus_size | input | 2 | Transfer size code |
| xfer_start | input | 1 | Transfer-start pulse |
| addr_strobe | input | 1 | Address strobe (alternative start) |
| cfg_base | input | NWIN*AW | Per-window base addresses, window i at [i*AW +: AW] |
| cfg_mask | input | NWIN*AW | Per-window don't-care masks |
| cfg_ext_en | input | NWIN | Per-window enable for external-master hits |
| cfg_auto_ack | input | NWIN | Per-window auto-acknowledge enable |
| cfg_lane_on | input | NWIN | Per-window byte-lane enable switch |
| cfg_waits | input | NWIN*WSW | Per-window wait-state counts |
| chip_sel | output | NWIN | Chip selects, one-hot or zero |
| lane_en | output | 4 | Byte-lane enables, bit 3 = offset 0 |
| xfer_ack | output | 1 | Transfer acknowledge pulse |
| proto_err | output | 1 | Both start inputs seen together |

## Verification
The bench builds the block with four windows, a 16-bit address and a 3-bit wait count. This setup lets it reach the largest wait count of seven as well as zero. The windows overlap in pairs: a low window lies inside a wider high one. One pair lets priority decide the match. In the other pair the low window is disabled, so the disabled-window fallthrough of R2 is reachable. The held no-acknowledge window also turns off lane enables, so the hold of R8 and the gating of R4 are checked in the same cycles.

// File: rtl/emcs_pkg.sv
package emcs_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  // Lane mask for a 32-bit port, bit 3 is byte offset 0.
  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] ofs);
    logic [3:0] m;
    case (xfer_size_e'(sz))
      SZ_BYTE: m = 4'b1000 >> ofs;
      SZ_WORD: m = ofs[1] ? 4'b0011 : 4'b1100;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/emcs_win_match.sv
module emcs_win_match #(
  parameter int NWIN = 4,
  parameter int AW   = 32,
  parameter int WSW  = 4
) (
  input  logic [AW-1:0]      addr,
  input  logic [NWIN*AW-1:0] base,
  input  logic [NWIN*AW-1:0] mask,
  input  logic [NWIN-1:0]    ext_en,
  input  logic [NWIN-1:0]    auto_ack,
  input  logic [NWIN-1:0]    lane_on,
  input  logic [NWIN*WSW-1:0] waits,
  output logic               hit,
  output logic [NWIN-1:0]    hit_oh,
  output logic               hit_auto,
  output logic               hit_lane_on,
  output logic [WSW-1:0]     hit_waits
);
  logic [NWIN-1:0] match;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign match[i] = ext_en[i] &&
      (((addr ^ base[i*AW +: AW]) & ~mask[i*AW +: AW]) == '0);
  end

  always_comb begin
    hit         = 1'b0;
    hit_oh      = '0;
    hit_auto    = 1'b0;
    hit_lane_on = 1'b0;
    hit_waits   = '0;
    // Walk downward so the lowest-numbered match is written last.
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit         = 1'b1;
        hit_oh      = '0;
        hit_oh[i]   = 1'b1;
        hit_auto    = auto_ack[i];
        hit_lane_on = lane_on[i];
        hit_waits   = waits[i*WSW +: WSW];
      end
    end
  end
endmodule

// File: rtl/emcs_lane_gen.sv
module emcs_lane_gen (
  input  logic [1:0] size,
  input  logic [1:0] ofs,
  input  logic       lane_on,
  output logic [3:0] lanes
);
  import emcs_pkg::*;
  always_comb lanes = lane_on ? lane_mask(size, ofs) : 4'b0000;
endmodule

// File: rtl/emcs_xfer_ctl.sv
module emcs_xfer_ctl #(
  parameter int NWIN = 4,
  parameter int WSW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ts,
  input  logic            start_as,
  input  logic            hit,
  input  logic [NWIN-1:0] hit_oh,
  input  logic            hit_auto,
  input  logic [3:0]      hit_lanes,
  input  logic [WSW-1:0]  hit_waits,
  output logic [NWIN-1:0] cs,
  output logic [3:0]      lanes,
  output logic            ack,
  output logic            err
);
  logic           active_q;
  logic           auto_q;
  logic [WSW-1:0] cnt_q;
  logic           start_ok;
  logic           can_take;

  assign start_ok = start_ts ^ start_as;
  assign ack      = active_q && auto_q && (cnt_q == '0);
  assign can_take = !active_q || ack || !auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      auto_q   <= 1'b0;
      cnt_q    <= '0;
      cs       <= '0;
      lanes    <= '0;
      err      <= 1'b0;
    end else begin
      err <= start_ts && start_as;
      if (start_ok && can_take) begin
        active_q <= hit;
        auto_q   <= hit && hit_auto;
        cnt_q    <= hit ? hit_waits : '0;
        cs       <= hit ? hit_oh : '0;
        lanes    <= hit ? hit_lanes : 4'b0000;
      end else if (ack) begin
        active_q <= 1'b0;
        auto_q   <= 1'b0;
        cs       <= '0;
        lanes    <= '0;
      end else if (active_q && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/emcs_responder.sv
module emcs_responder #(
  parameter int NWIN = 4,
  parameter int AW   = 32,
  parameter int WSW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [1:0]         bus_size,
  input  logic               xfer_start,
  input  logic               addr_strobe,
  input  logic [NWIN*AW-1:0] cfg_base,
  input  logic [NWIN*AW-1:0] cfg_mask,
  input  logic [NWIN-1:0]    cfg_ext_en,
  input  logic [NWIN-1:0]    cfg_auto_ack,
  input  logic [NWIN-1:0]    cfg_lane_on,
  input  logic [NWIN*WSW-1:0] cfg_waits,
  output logic [NWIN-1:0]    chip_sel,
  output logic [3:0]         lane_en,
  output logic               xfer_ack,
  output logic               proto_err
);
  logic            hit;
  logic [NWIN-1:0] hit_oh;
  logic            hit_auto;
  logic            hit_lane_on;
  logic [WSW-1:0]  hit_waits;
  logic [3:0]      hit_lanes;

  emcs_win_match #(.NWIN(NWIN), .AW(AW), .WSW(WSW)) u_match (
    .addr(bus_addr), .base(cfg_base), .mask(cfg_mask), .ext_en(cfg_ext_en),
    .auto_ack(cfg_auto_ack), .lane_on(cfg_lane_on), .waits(cfg_waits),
    .hit(hit), .hit_oh(hit_oh), .hit_auto(hit_auto),
    .hit_lane_on(hit_lane_on), .hit_waits(hit_waits)
  );

  emcs_lane_gen u_lanes (
    .size(bus_size), .ofs(bus_addr[1:0]), .lane_on(hit_lane_on), .lanes(hit_lanes)
  );

  emcs_xfer_ctl #(.NWIN(NWIN), .WSW(WSW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_ts(xfer_start), .start_as(addr_strobe),
    .hit(hit), .hit_oh(hit_oh), .hit_auto(hit_auto), .hit_lanes(hit_lanes),
    .hit_waits(hit_waits), .cs(chip_sel), .lanes(lane_en), .ack(xfer_ack),
    .err(proto_err)
  );
endmodule

// File: rtl/emcs_responder_chk.sv
module emcs_responder_chk #(
  parameter int NWIN = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_start,
  input logic            addr_strobe,
  input logic [NWIN-1:0] chip_sel,
  input logic [3:0]      lane_en,
  input logic            xfer_ack,
  input logic            proto_err
);
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chip_sel));

  p_ack_has_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> chip_sel != '0);

  p_lanes_need_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en != 4'b0000 |-> chip_sel != '0);

  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack && !(xfer_start ^ addr_strobe) |=> !xfer_ack && chip_sel == '0);

  p_err_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && addr_strobe |=> proto_err);

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_start && addr_strobe) |=> !proto_err);

  p_clash_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && addr_strobe && chip_sel == '0 |=> chip_sel == '0);
endmodule

bind emcs_responder emcs_responder_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .addr_strobe(addr_strobe),
  .chip_sel(chip_sel), .lane_en(lane_en), .xfer_ack(xfer_ack), .proto_err(proto_err)
);

// File: tb/sim_emcs_responder.sv
module sim_emcs_responder;
  localparam int NWIN = 4;
  localparam int AW   = 16;
  localparam int WSW  = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [AW-1:0]      bus_addr = '0;
  logic [1:0]         bus_size = '0;
  logic               xfer_start = 1'b0;
  logic               addr_strobe = 1'b0;
  logic [NWIN*AW-1:0] cfg_base;
  logic [NWIN*AW-1:0] cfg_mask;
  logic [NWIN-1:0]    cfg_ext_en;
  logic [NWIN-1:0]    cfg_auto_ack;
  logic [NWIN-1:0]    cfg_lane_on;
  logic [NWIN*WSW-1:0] cfg_waits;
  logic [NWIN-1:0]    chip_sel;
  logic [3:0]         lane_en;
  logic               xfer_ack;
  logic               proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] cs;
    logic [3:0] be;
    logic       ack;
    logic       err;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  emcs_responder #(.NWIN(NWIN), .AW(AW), .WSW(WSW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .xfer_start(xfer_start), .addr_strobe(addr_strobe), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_ext_en(cfg_ext_en), .cfg_auto_ack(cfg_auto_ack),
    .cfg_lane_on(cfg_lane_on), .cfg_waits(cfg_waits), .chip_sel(chip_sel),
    .lane_en(lane_en), .xfer_ack(xfer_ack), .proto_err(proto_err)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (chip_sel !== e.cs || lane_en !== e.be || xfer_ack !== e.ack || proto_err !== e.err) begin
      fails++;
      $display("FAIL %s: cs=%b be=%b ack=%b err=%b expected cs=%b be=%b ack=%b err=%b",
               e.tag, chip_sel, lane_en, xfer_ack, proto_err, e.cs, e.be, e.ack, e.err);
    end
  endtask

  // Monitor: pops one expected item per clock, sampled after the edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e);
    end
  end

  // Driver: sets inputs at the falling edge and queues the outputs due after the next rising edge.
  task automatic step(input logic ts, input logic as, input logic [AW-1:0] a,
                      input logic [1:0] sz, input logic [3:0] ecs, input logic [3:0] ebe,
                      input logic eack, input logic eerr, input string tag);
    exp_t e;
    @(negedge clk);
    xfer_start  = ts;
    addr_strobe = as;
    bus_addr    = a;
    bus_size    = sz;
    e.cs = ecs; e.be = ebe; e.ack = eack; e.err = eerr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic [3:0] ecs, input logic [3:0] ebe, input logic eack,
                      input string tag);
    step(1'b0, 1'b0, '0, 2'b00, ecs, ebe, eack, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // w0: 0x10xx, zero waits. w1: 0x1xxx, wider, waits 2. w2: 0x40xx disabled. w3: 0x4xxx, no ack, no lanes.
    cfg_base     = {16'h4000, 16'h4000, 16'h1000, 16'h1000};
    cfg_mask     = {16'h0FFF, 16'h00FF, 16'h0FFF, 16'h00FF};
    cfg_ext_en   = 4'b1011;
    cfg_auto_ack = 4'b0111;
    cfg_lane_on  = 4'b0111;
    cfg_waits    = {3'd7, 3'd0, 3'd2, 3'd0};

    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (chip_sel !== 4'b0 || lane_en !== 4'b0 || xfer_ack !== 1'b0 || proto_err !== 1'b0) begin
      fails++;
      $display("FAIL R9: cs=%b be=%b ack=%b err=%b expected all zero",
               chip_sel, lane_en, xfer_ack, proto_err);
    end
    @(negedge clk);
    rst_n = 1'b1;

    idle(4'b0000, 4'b0000, 1'b0, "R9 idle after reset");
    // Zero-wait window, back-to-back on both start kinds (R1, R7, R4).
    step(1, 0, 16'h1000, 2'b00, 4'b0001, 4'b1111, 1, 0, "R1 R7 long in w0");
    step(0, 1, 16'h1003, 2'b01, 4'b0001, 4'b0001, 1, 0, "R7 R3 strobe start byte ofs3");
    step(1, 0, 16'h1002, 2'b01, 4'b0001, 4'b0010, 1, 0, "R7 R4 byte ofs2");
    idle(4'b0000, 4'b0000, 0, "R6 release after ack");
    // Priority fallthrough to wider window, two waits, mid-wait start ignored (R1, R5).
    step(1, 0, 16'h1102, 2'b10, 4'b0010, 4'b0011, 0, 0, "R1 R5 w1 word hi");
    step(1, 0, 16'h1000, 2'b00, 4'b0010, 4'b0011, 0, 0, "R5 start ignored while waiting");
    idle(4'b0010, 4'b0011, 1, "R5 ack after two waits");
    idle(4'b0000, 4'b0000, 0, "R6 single pulse and release");
    // Both start inputs together (R3).
    step(1, 1, 16'h1000, 2'b00, 4'b0000, 4'b0000, 0, 1, "R3 clash flags error");
    idle(4'b0000, 4'b0000, 0, "R3 error one clock");
    // Disabled w2 falls to w3: held, no ack, no lanes (R2, R8, R4).
    step(1, 0, 16'h4010, 2'b01, 4'b1000, 4'b0000, 0, 0, "R2 R4 disabled window skipped");
    idle(4'b1000, 4'b0000, 0, "R8 held");
    idle(4'b1000, 4'b0000, 0, "R8 held no ack");
    step(0, 1, 16'h5000, 2'b00, 4'b0000, 4'b0000, 0, 0, "R8 unmatched start closes hold");
    idle(4'b0000, 4'b0000, 0, "R1 no match stays idle");
    step(1, 0, 16'h4010, 2'b00, 4'b1000, 4'b0000, 0, 0, "R8 hold again");
    step(1, 0, 16'h1001, 2'b01, 4'b0001, 4'b0100, 1, 0, "R8 new start replaces hold");
    idle(4'b0000, 4'b0000, 0, "R6 release");
    step(1, 0, 16'h1000, 2'b10, 4'b0001, 4'b1100, 1, 0, "R4 word low half");
    idle(4'b0000, 4'b0000, 0, "R6 release");
    step(0, 1, 16'h5000, 2'b00, 4'b0000, 4'b0000, 0, 0, "R1 no match no cycle");
    // Largest wait count, line size (R5, R4).
    @(negedge clk);
    cfg_waits = {3'd7, 3'd0, 3'd7, 3'd0};
    q.push_back('{4'b0000, 4'b0000, 1'b0, 1'b0, "R1 idle before reconfig"});
    step(1, 0, 16'h1200, 2'b11, 4'b0010, 4'b1111, 0, 0, "R5 R4 line seven waits");
    for (int k = 0; k < 6; k++) idle(4'b0010, 4'b1111, 0, "R5 waiting");
    idle(4'b0010, 4'b1111, 1, "R5 ack after seven waits");
    idle(4'b0000, 4'b0000, 0, "R6 release");

    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule